// File: doc/BRIEF.md
# Analog Trigger and Capture Controller

This block sits behind the sample inputs of a two-channel scope. Each clock it takes one 10-bit sample from each of five streams: two analog channels, an external digital trigger stream and two generator channels. It picks one stream by a select code. It watches that stream for a rising level crossing with a hysteresis band, and it stores a window of the same stream in an on-chip ring buffer. A programmable share of the window holds samples from before the trigger.

The block starts idle. An arm pulse begins an acquisition. The buffer first fills its pre-trigger share, then the block waits for a trigger and records the rest of the window. After the window is complete, a holdoff period follows, counted in clock cycles (10 ns steps at 100 MHz). In Auto mode a capture is forced when no trigger comes within a timeout. Normal mode waits as long as it takes. Both of these modes restart by themselves after the holdoff. Single mode stops after one window until the next arm pulse. Software reads the finished window by a logical index, where index 0 is the oldest sample.

Top module: `scope_capture_ctrl`

## Requirements
- R1: After reset, cap_done and trig_seen are 0, and no capture starts until arm is pulsed while the block is idle.
- R2: src_sel codes 0 to 4 pick stream 0 to 4 of src_data (stream k occupies bits k*SMP_W upward), and codes 5 to 7 pick stream 0. The chosen sample passes one register before it is compared or stored.
- R3: A trigger qualifies on a registered sample that is at or above level+hyst (clamped to full scale), and only if an earlier sample was at or below level-hyst (clamped to 0) with no sample at or above level+hyst since then. trig_seen goes high for exactly one cycle, in the cycle after a qualifying sample is accepted.
- R4: The pre-trigger count is floor(min(pre_pct,100)*DEPTH/100), capped at DEPTH-1, and is latched when an acquisition starts. The window holds that many samples before the trigger sample, then the trigger sample and the samples that follow it, DEPTH samples in all.
- R5: Qualifying crossings that occur while the pre-trigger share is still filling after an acquisition starts are ignored.
- R6: In Auto mode (trig_mode 0), once the block has waited auto_tmo cycles for a trigger, it captures the current sample as the trigger point. A forced capture does not raise trig_seen.
- R7: In Normal mode (trig_mode 1, and the unused code 3), the block waits for a trigger without limit. Both Auto and Normal mode start a new acquisition by themselves when the holdoff ends.
- R8: In Single mode (trig_mode 2), the block goes idle after the holdoff and keeps its window until arm is pulsed. An arm pulse during an acquisition or during the holdoff has no effect.
- R9: The holdoff lasts holdoff+1 cycles. In Auto and Normal mode, cap_done stays high for exactly that long before the next acquisition clears it.
- R10: cap_done rises in the cycle after the last window sample is written. It stays high through the holdoff, and in Single mode also through the idle time that follows.
- R11: rd_data returns the window sample at logical index rd_idx (0 = oldest) one clock after rd_idx is presented. rd_idx must be below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | N_SRC*SMP_W | Five sample streams, stream k at bits k*SMP_W upward |
| src_sel | input | SEL_W | Trigger and capture source select |
| trig_mode | input | 2 | 0 Auto, 1 Normal, 2 Single, 3 acts as Normal |
| arm | input | 1 | One-cycle arm / re-arm pulse, acted on when idle |
| level | input | SMP_W | Trigger level code |
| hyst | input | SMP_W | Hysteresis half-band in codes |
| pre_pct | input | PCT_W | Pre-trigger share in percent (0 to 100) |
| holdoff | input | CW | Holdoff length in cycles, minus one |
| auto_tmo | input | CW | Auto mode wait limit in cycles |
| rd_idx | input | AW | Logical read index into the finished window |
| rd_data | output | SMP_W | Window sample, one cycle after rd_idx |
| cap_done | output | 1 | A complete window is held in the buffer |
| trig_seen | output | 1 | One-cycle pulse for each accepted real trigger |

## Verification
The stimulus is a set of triangle waves with a different period on each stream, so every select code yields a window that no other code could produce. A flat stream that arms the comparator but never crosses the upper threshold separates a real trigger from an Auto timeout, and shows that Normal mode waits without limit. Pre-trigger shares of 0, 25, 50, 75, 90 and 100 percent, on waves that cross during the fill, show whether early crossings are dropped and whether the window split is correct. Arm pulses given while the block waits, together with the measured cap_done duration, test the Single mode stop and the holdoff length.

// File: rtl/scope_cap_pkg.sv
package scope_cap_pkg;

   typedef enum logic [2:0] {
      CS_IDLE = 3'd0,
      CS_PRE  = 3'd1,
      CS_WAIT = 3'd2,
      CS_POST = 3'd3,
      CS_HOLD = 3'd4
   } cap_state_e;

   localparam logic [1:0] MODE_AUTO   = 2'd0;
   localparam logic [1:0] MODE_NORMAL = 2'd1;
   localparam logic [1:0] MODE_SINGLE = 2'd2;

   localparam int PCT_FULL = 100;

endpackage

// File: rtl/scope_src_mux.sv
module scope_src_mux #(
   parameter int SMP_W = 10,
   parameter int N_SRC = 5,
   parameter int SEL_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC*SMP_W-1:0]   src_flat,
   input  logic [SEL_W-1:0]         sel,
   output logic [SMP_W-1:0]         smp_q
);

   logic [SMP_W-1:0] lane [N_SRC];
   logic [SMP_W-1:0] pick;

   for (genvar g = 0; g < N_SRC; g++) begin : g_lane
      assign lane[g] = src_flat[g*SMP_W +: SMP_W];
   end

   // Out-of-range codes fall back to lane 0
   always_comb begin
      pick = lane[0];
      for (int i = 1; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) pick = lane[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= '0;
      else        smp_q <= pick;
   end

endmodule

// File: rtl/scope_hyst_det.sv
module scope_hyst_det #(
   parameter int SMP_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] smp,
   input  logic [SMP_W-1:0] level,
   input  logic [SMP_W-1:0] hyst,
   output logic             fire
);

   logic [SMP_W:0]   hi_sum;
   logic [SMP_W-1:0] thr_hi;
   logic [SMP_W-1:0] thr_lo;
   logic             low_seen_q;
   logic             low_seen_d;

   // Band edges saturate at the ends of the code range
   assign hi_sum = {1'b0, level} + {1'b0, hyst};
   assign thr_hi = hi_sum[SMP_W] ? '1 : hi_sum[SMP_W-1:0];
   assign thr_lo = (level >= hyst) ? (level - hyst) : '0;

   always_comb begin
      low_seen_d = low_seen_q;
      if (smp <= thr_lo)      low_seen_d = 1'b1;
      else if (smp >= thr_hi) low_seen_d = 1'b0;
   end

   assign fire = low_seen_q && (smp >= thr_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_seen_q <= 1'b0;
      else        low_seen_q <= low_seen_d;
   end

endmodule

// File: rtl/scope_ring_buf.sv
module scope_ring_buf #(
   parameter int SMP_W = 10,
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [SMP_W-1:0] wr_data,
   input  logic [AW-1:0]    base,
   input  logic [AW-1:0]    rd_idx,
   output logic [SMP_W-1:0] rd_data
);

   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [SMP_W-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_addr;

   if (POW2) begin : g_wrap_free
      assign rd_addr = base + rd_idx;
   end else begin : g_wrap_cmp
      logic [AW:0] raw;
      assign raw     = {1'b0, base} + {1'b0, rd_idx};
      assign rd_addr = (raw >= (AW+1)'(DEPTH)) ? AW'(raw - (AW+1)'(DEPTH)) : raw[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/scope_capture_seq.sv
module scope_capture_seq
   import scope_cap_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int AW    = 10,
   parameter int CW    = 32,
   parameter int PCT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             arm,
   input  logic [PCT_W-1:0] pre_pct,
   input  logic [CW-1:0]    holdoff,
   input  logic [CW-1:0]    tmo,
   input  logic             fire,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [AW-1:0]    base_addr,
   output logic             cap_done,
   output logic             trig_seen,
   output cap_state_e       st
);

   localparam int          PW      = PCT_W + AW + 1;
   localparam bit          POW2    = (DEPTH == (1 << AW));
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

   cap_state_e       st_q, st_d;
   logic [CW-1:0]    cnt_q, cnt_d, cnt_inc;
   logic [AW-1:0]    pre_q, pre_d, pre_new;
   logic [AW-1:0]    wptr_q, wptr_nx;
   logic [AW-1:0]    base_q, base_d, base_new;
   logic             done_q, done_d;
   logic             trig_q;
   logic             take_real, take_force, take, start;
   logic [AW:0]      post_len;
   logic [AW:0]      base_raw;
   logic [PCT_W-1:0] pct_c;
   logic [PW-1:0]    prod, quot;

   // Pre-trigger share, from percent to samples
   assign pct_c   = (pre_pct > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : pre_pct;
   assign prod    = PW'(pct_c) * PW'(DEPTH);
   assign quot    = prod / PW'(PCT_FULL);
   assign pre_new = (quot >= PW'(DEPTH)) ? AW'(DEPTH - 1) : quot[AW-1:0];

   assign post_len = DEPTH_V - {1'b0, pre_q};
   assign cnt_inc  = cnt_q + 1'b1;

   // Oldest window sample: trigger address minus the pre-trigger share
   assign base_raw = {1'b0, wptr_q} + post_len;
   assign base_new = (base_raw >= DEPTH_V) ? AW'(base_raw - DEPTH_V) : base_raw[AW-1:0];

   if (POW2) begin : g_ptr_free
      assign wptr_nx = wptr_q + 1'b1;
   end else begin : g_ptr_cmp
      assign wptr_nx = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
   end

   assign take_real  = (st_q == CS_WAIT) && fire;
   assign take_force = (st_q == CS_WAIT) && (mode == MODE_AUTO) && (cnt_q >= tmo);
   assign take       = take_real || take_force;
   assign wr_en      = (st_q == CS_PRE) || (st_q == CS_WAIT) || (st_q == CS_POST);

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      pre_d  = pre_q;
      done_d = done_q;
      base_d = base_q;
      start  = 1'b0;
      case (st_q)
         CS_IDLE: begin
            if (arm) start = 1'b1;
         end
         CS_PRE: begin
            if (cnt_inc == CW'(pre_q)) begin
               st_d  = CS_WAIT;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_inc;
            end
         end
         CS_WAIT: begin
            if (take) begin
               base_d = base_new;
               if (post_len == (AW+1)'(1)) begin
                  st_d   = CS_HOLD;
                  cnt_d  = '0;
                  done_d = 1'b1;
               end else begin
                  st_d  = CS_POST;
                  cnt_d = CW'(1);
               end
            end else begin
               cnt_d = cnt_inc;
            end
         end
         CS_POST: begin
            if (cnt_inc == CW'(post_len)) begin
               st_d   = CS_HOLD;
               cnt_d  = '0;
               done_d = 1'b1;
            end else begin
               cnt_d = cnt_inc;
            end
         end
         CS_HOLD: begin
            if (cnt_q >= holdoff) begin
               if (mode == MODE_SINGLE) st_d = CS_IDLE;
               else                     start = 1'b1;
            end else begin
               cnt_d = cnt_inc;
            end
         end
         default: st_d = CS_IDLE;
      endcase
      if (start) begin
         pre_d  = pre_new;
         st_d   = (pre_new == '0) ? CS_WAIT : CS_PRE;
         cnt_d  = '0;
         done_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CS_IDLE;
         cnt_q  <= '0;
         pre_q  <= '0;
         wptr_q <= '0;
         base_q <= '0;
         done_q <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         pre_q  <= pre_d;
         base_q <= base_d;
         done_q <= done_d;
         trig_q <= take_real;
         if (wr_en) wptr_q <= wptr_nx;
      end
   end

   assign wr_addr   = wptr_q;
   assign base_addr = base_q;
   assign cap_done  = done_q;
   assign trig_seen = trig_q;
   assign st        = st_q;

endmodule

// File: rtl/scope_capture_ctrl.sv
module scope_capture_ctrl
   import scope_cap_pkg::*;
#(
   parameter int SMP_W = 10,
   parameter int N_SRC = 5,
   parameter int SEL_W = 3,
   parameter int DEPTH = 1024,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = 32,
   parameter int PCT_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC*SMP_W-1:0] src_data,
   input  logic [SEL_W-1:0]       src_sel,
   input  logic [1:0]             trig_mode,
   input  logic                   arm,
   input  logic [SMP_W-1:0]       level,
   input  logic [SMP_W-1:0]       hyst,
   input  logic [PCT_W-1:0]       pre_pct,
   input  logic [CW-1:0]          holdoff,
   input  logic [CW-1:0]          auto_tmo,
   input  logic [AW-1:0]          rd_idx,
   output logic [SMP_W-1:0]       rd_data,
   output logic                   cap_done,
   output logic                   trig_seen
);

   if (DEPTH < 4) begin : g_chk_depth
      $error("scope_capture_ctrl: DEPTH must be at least 4");
   end
   if (AW != $clog2(DEPTH)) begin : g_chk_aw
      $error("scope_capture_ctrl: AW must equal clog2(DEPTH)");
   end
   if (N_SRC < 1 || N_SRC > (1 << SEL_W)) begin : g_chk_src
      $error("scope_capture_ctrl: N_SRC does not fit SEL_W");
   end
   if (CW < AW + 1) begin : g_chk_cw
      $error("scope_capture_ctrl: CW too narrow for DEPTH");
   end
   if (PCT_W < 7) begin : g_chk_pct
      $error("scope_capture_ctrl: PCT_W must hold 100");
   end
   if (SMP_W < 2) begin : g_chk_smp
      $error("scope_capture_ctrl: SMP_W must be at least 2");
   end

   logic [SMP_W-1:0] smp_r;
   logic             hit;
   logic             buf_we;
   logic [AW-1:0]    buf_wa;
   logic [AW-1:0]    win_base;
   cap_state_e       seq_st;

   scope_src_mux #(.SMP_W(SMP_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) mux_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_flat (src_data),
      .sel      (src_sel),
      .smp_q    (smp_r)
   );

   scope_hyst_det #(.SMP_W(SMP_W)) det_i (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (smp_r),
      .level (level),
      .hyst  (hyst),
      .fire  (hit)
   );

   scope_capture_seq #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .PCT_W(PCT_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (trig_mode),
      .arm       (arm),
      .pre_pct   (pre_pct),
      .holdoff   (holdoff),
      .tmo       (auto_tmo),
      .fire      (hit),
      .wr_en     (buf_we),
      .wr_addr   (buf_wa),
      .base_addr (win_base),
      .cap_done  (cap_done),
      .trig_seen (trig_seen),
      .st        (seq_st)
   );

   scope_ring_buf #(.SMP_W(SMP_W), .DEPTH(DEPTH), .AW(AW)) buf_i (
      .clk     (clk),
      .wr_en   (buf_we),
      .wr_addr (buf_wa),
      .wr_data (smp_r),
      .base    (win_base),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/scope_capture_chk.sv
module scope_capture_chk
   import scope_cap_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  cap_state_e    st,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          cap_done,
   input  logic          trig_seen
);

   AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr < AW'(DEPTH - 1) || wr_addr == AW'(DEPTH - 1))); // R4

   AST_PREFILL_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CS_PRE) |=> !trig_seen); // R5

   AST_IDLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CS_IDLE && !arm) |=> (st == CS_IDLE)); // R8

   AST_HOLD_HAS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CS_HOLD) |-> cap_done); // R9

   AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_seen |=> !trig_seen); // R3

   AST_DONE_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_done) |-> ($past(st) == CS_WAIT || $past(st) == CS_POST)); // R10

endmodule

bind scope_capture_ctrl scope_capture_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .arm       (arm),
   .st        (seq_st),
   .wr_en     (buf_we),
   .wr_addr   (buf_wa),
   .cap_done  (cap_done),
   .trig_seen (trig_seen)
);

// File: tb/scope_capture_ctrl_tb_top.sv
module scope_capture_ctrl_tb_top;

   localparam int D  = 40;
   localparam int SW = 10;
   localparam int NS = 5;
   localparam int AWB = $clog2(D);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NS*SW-1:0]  src = '0;
   logic [2:0]        sel;
   logic [1:0]        mode;
   logic              arm;
   logic [SW-1:0]     level, hyst;
   logic [6:0]        pct;
   logic [31:0]       hold, tmo;
   logic [AWB-1:0]    rd_idx;
   logic [SW-1:0]     rd_data;
   logic              done, trig;

   always #5 clk = ~clk;

   scope_capture_ctrl #(.SMP_W(SW), .N_SRC(NS), .SEL_W(3), .DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_data(src), .src_sel(sel), .trig_mode(mode),
      .arm(arm), .level(level), .hyst(hyst), .pre_pct(pct), .holdoff(hold),
      .auto_tmo(tmo), .rd_idx(rd_idx), .rd_data(rd_data), .cap_done(done),
      .trig_seen(trig)
   );

   int  nchk = 0;
   int  nfail = 0;
   bit  ended = 0;
   int  tcyc = 0;
   bit  flat = 0;
   int  flat_val = 300;
   bit  saw_trig = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int tri_wave(input int t, input int p);
      int ph;
      ph = t % p;
      return (ph < p / 2) ? (ph * 2000) / p : ((p - ph) * 2000) / p;
   endfunction

   // Stimulus streams, changed away from the sampling edge
   always @(negedge clk) begin
      tcyc++;
      for (int k = 0; k < NS; k++) begin
         src[k*SW +: SW] <= flat ? SW'(flat_val) : SW'(tri_wave(tcyc + k * 13, 36 + k * 10));
      end
      if (trig) saw_trig <= 1'b1;
   end

   // Behavioural reference, advanced on every sampling edge
   int m_smp, m_armed, m_ph, m_cnt, m_pre, m_done, m_trig;
   int hist[$];
   int win[$];
   int r_hi, r_lo, r_fire, r_new, r_start, r_p, r_sel;

   task automatic enter_hold();
      m_ph = 4; m_cnt = 0; m_done = 1;
      win.delete();
      for (int i = hist.size() - D; i < hist.size(); i++) win.push_back(hist[i]);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_smp = 0; m_armed = 0; m_ph = 0; m_cnt = 0; m_pre = 0; m_done = 0; m_trig = 0;
         hist.delete();
      end else begin
         r_hi = int'(level) + int'(hyst);
         if (r_hi > 1023) r_hi = 1023;
         r_lo = int'(level) - int'(hyst);
         if (r_lo < 0) r_lo = 0;
         r_fire = (m_armed != 0 && m_smp >= r_hi) ? 1 : 0;
         r_new = 0;
         r_start = 0;
         case (m_ph)
            0: if (arm) r_start = 1;
            1: begin
               hist.push_back(m_smp);
               if (m_cnt + 1 == m_pre) begin m_ph = 2; m_cnt = 0; end
               else m_cnt++;
            end
            2: begin
               hist.push_back(m_smp);
               if (r_fire != 0 || (mode == 2'd0 && m_cnt >= int'(tmo))) begin
                  r_new = r_fire;
                  if (D - m_pre == 1) enter_hold();
                  else begin m_ph = 3; m_cnt = 1; end
               end else m_cnt++;
            end
            3: begin
               hist.push_back(m_smp);
               if (m_cnt + 1 == D - m_pre) enter_hold();
               else m_cnt++;
            end
            default: begin
               if (m_cnt >= int'(hold)) begin
                  if (mode == 2'd2) m_ph = 0;
                  else r_start = 1;
               end else m_cnt++;
            end
         endcase
         if (r_start != 0) begin
            r_p = (int'(pct) > 100) ? 100 : int'(pct);
            m_pre = (r_p * D) / 100;
            if (m_pre >= D) m_pre = D - 1;
            m_ph = (m_pre == 0) ? 2 : 1;
            m_cnt = 0;
            m_done = 0;
            hist.delete();
         end
         m_trig = r_new;
         if (m_smp <= r_lo) m_armed = 1;
         else if (m_smp >= r_hi) m_armed = 0;
         r_sel = (int'(sel) < NS) ? int'(sel) : 0;
         m_smp = int'(src[r_sel*SW +: SW]);
      end
   end

   // Every-cycle comparison of the status outputs
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         chk(done == m_done[0], "R10 cap_done per cycle", int'(done), m_done);
         chk(trig == m_trig[0], "R3 trig_seen per cycle", int'(trig), m_trig);
      end
   end

   task automatic pulse_arm();
      @(negedge clk) arm = 1'b1;
      @(negedge clk) arm = 1'b0;
   endtask

   task automatic wait_done(input int lim, input string tag);
      int n = 0;
      while (!done && n < lim) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, tag, int'(done), 1);
   endtask

   task automatic read_window(input string tag);
      for (int i = 0; i < D; i++) begin
         rd_idx = AWB'(i);
         @(negedge clk);
         chk(int'(rd_data) == win[i], tag, int'(rd_data), win[i]);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int n;
      sel = 3'd0; mode = 2'd2; arm = 1'b0; level = 10'd500; hyst = 10'd50;
      pct = 7'd25; hold = 32'd3; tmo = 32'd1000; rd_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R1 cap_done after reset", int'(done), 0);
      chk(trig == 1'b0, "R1 trig_seen after reset", int'(trig), 0);
      repeat (40) @(negedge clk);
      chk(done == 1'b0, "R1 no capture without arm", int'(done), 0);

      // Single mode, stream 0, quarter pre-trigger
      pulse_arm();
      wait_done(500, "R10 done after single capture");
      repeat (10) @(negedge clk);
      read_window("R4 R11 stream0 25pct window");
      repeat (50) @(negedge clk);
      chk(done == 1'b1, "R8 single keeps window while idle", int'(done), 1);
      read_window("R8 window unchanged in idle");

      // Source codes and pre-trigger extremes
      sel = 3'd3; pct = 7'd0;
      pulse_arm();
      wait_done(500, "R2 capture on stream 3");
      read_window("R2 stream3 0pct window");
      sel = 3'd1; pct = 7'd100;
      pulse_arm();
      wait_done(500, "R4 capture at 100pct");
      read_window("R4 stream1 100pct window");
      sel = 3'd4; pct = 7'd90;
      pulse_arm();
      wait_done(500, "R2 capture on stream 4");
      read_window("R2 stream4 90pct window");
      sel = 3'd6; pct = 7'd120;
      pulse_arm();
      wait_done(500, "R2 capture with code 6");
      read_window("R2 code6 falls back to stream0");
      sel = 3'd2; pct = 7'd50;
      pulse_arm();
      wait_done(500, "R2 capture on stream 2");
      read_window("R2 stream2 50pct window");

      // Crossings during the pre-trigger fill are dropped
      sel = 3'd0; pct = 7'd75;
      @(negedge clk) arm = 1'b1;
      @(negedge clk) arm = 1'b0;
      n = 0;
      while (!done && n < 500) begin @(negedge clk); n++; end
      chk(n >= D - 1, "R5 capture not earlier than fill", n, D - 1);
      read_window("R5 window after 75pct fill");

      // Arm ignored while waiting in Single mode
      flat = 1; pct = 7'd25;
      pulse_arm();
      repeat (60) @(negedge clk);
      pulse_arm();
      repeat (20) @(negedge clk);
      chk(done == 1'b0, "R8 arm during wait has no effect", int'(done), 0);
      flat = 0;
      wait_done(500, "R8 capture after stray arm");
      read_window("R8 window after stray arm");
      repeat (10) @(negedge clk);

      // Auto mode on a flat stream: forced capture, no trigger pulse
      flat = 1; mode = 2'd0; tmo = 32'd15; hold = 32'd80;
      saw_trig = 0;
      pulse_arm();
      wait_done(500, "R6 auto forced capture");
      chk(saw_trig == 1'b0, "R6 forced capture without trig_seen", int'(saw_trig), 0);
      read_window("R6 forced window");

      // Normal mode on the same flat stream waits without limit
      mode = 2'd1;
      n = 0;
      while (done && n < 500) begin @(negedge clk); n++; end
      repeat (300) @(negedge clk);
      chk(done == 1'b0, "R7 normal mode keeps waiting", int'(done), 0);

      // Holdoff length and automatic restart
      hold = 32'd20;
      flat = 0;
      wait_done(500, "R7 normal capture on crossing");
      n = 0;
      while (done && n < 500) begin @(negedge clk); n++; end
      chk(n == 21, "R9 holdoff length in cycles", n, 21);
      wait_done(500, "R7 automatic restart captures again");
      mode = 2'd3;
      n = 0;
      while (done && n < 500) begin @(negedge clk); n++; end
      wait_done(500, "R7 code 3 acts as normal");
      mode = 2'd2;
      repeat (200) @(negedge clk);
      chk(done == 1'b1, "R8 single stops after capture", int'(done), 1);
      read_window("R8 final single window");

      finish_run();
   end

endmodule